// File: doc/BRIEF.md
# Timed Lock and Fuse Command Window

This block sits beside a processor core. It guards the only software path that can change the boot lock bits, and it also lets software read the lock and fuse bytes. Software opens a short command window by writing a fixed arming code to the control port. While the window is open, a store-program strobe programs lock bits from the data input. A load-program strobe instead returns a lock or fuse byte, chosen by the pointer address.

The window closes by itself. It closes when a command is taken, when its time runs out, or when a different value is written to the control port. While the EEPROM reports a write in progress, the block takes no arming write and no command. Lock storage and fuse storage are plain registers. The fuse values are fixed by parameters, and the lock byte resets to a parameter value.

Top module: `nvm_cmd_window`

## Requirements
- R1: A control write with bits 6:0 equal to 0001001 arms the window, whatever the value of bit 7. From the next cycle, ctrl_o reads 0x09: bit 3 is the lock-set flag and bit 0 is the enable flag. A control write of any other value closes the window. ctrl_o reads 0x00 whenever the window is closed.
- R2: A store strobe sampled in any of the four cycles after the arming write is accepted. lock_we_o is then high for exactly one cycle, starting in the cycle after the strobe.
- R3: A load strobe sampled in any of the three cycles after the arming write is accepted. rd_valid_o is high for one cycle, starting in the cycle after the strobe, and rd_data_o carries the selected byte in that same cycle.
- R4: If no command is accepted in the four cycles after arming, ctrl_o returns to 0x00. A load strobe in the fourth cycle is not accepted.
- R5: An accepted store or load closes the window. ctrl_o reads 0x00 in the cycle where lock_we_o or rd_valid_o is high.
- R6: An accepted store clears each lock bit 5..2 whose data_i bit is 0. A lock bit is never set back to 1. Data bits 7, 6, 1 and 0, the pointer, and lock bits 1:0 take no part in this.
- R7: Pointer 0x0000 reads the low fuse byte, 0x0001 reads the lock byte {1,1,lock[5:0]}, and 0x0003 reads the high fuse byte. Any other pointer reads 0xFF.
- R8: While ee_busy_i is high, control writes are ignored and strobes are not accepted. An open window keeps counting during this time.
- R9: An arming write made while the window is open restarts the four-cycle count.
- R10: A load strobe while the window is closed produces no rd_valid_o pulse.
- R11: If a store and a load arrive in the same cycle inside the window, only the store is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| store_i | input | 1 | Store-program strobe |
| load_i | input | 1 | Load-program strobe |
| ptr_i | input | PTR_W | Pointer address |
| data_i | input | 8 | Data register value used for lock programming |
| ee_busy_i | input | 1 | EEPROM write in progress |
| ctrl_o | output | 8 | Visible control bits (0x09 while armed) |
| lock_we_o | output | 1 | One-cycle pulse when lock bits are programmed |
| rd_valid_o | output | 1 | One-cycle pulse when a lock or fuse byte is returned |
| rd_data_o | output | 8 | Returned lock or fuse byte |

## Verification
The hardest cases to reach from the ports are at the edges of the window. These are a load arriving in the fourth cycle, where a store would still be accepted, and a re-arm that lands just before expiry and must stretch the window. Directed sequences place strobes at exact offsets from the arming write, with idle cycles counted out. A busy pulse is laid over an open window to show that the window keeps aging while commands are blocked. Long random runs then mix arming codes, strobe collisions and pointers, and a behavioural model tracks the window age as a plain integer.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
  localparam logic [7:0] ARM_CODE   = 8'h89;  // bit 7 forced to 1 before compare
  localparam logic [7:0] CTRL_ARMED = 8'h09;  // lock-set bit 3, enable bit 0
  localparam logic [7:0] PROG_KEEP  = 8'hC3;  // data bits that never clear lock
  localparam logic [7:0] RD_DEFAULT = 8'hFF;

  function automatic logic is_arm(input logic [7:0] wd);
    return (wd | 8'h80) == ARM_CODE;
  endfunction
endpackage

// File: rtl/nvw_window.sv
module nvw_window #(
  parameter int STORE_CYC = 4,
  parameter int LOAD_CYC  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic close_i,
  input  logic store_i,
  input  logic load_i,
  output logic open_o,
  output logic store_ok_o,
  output logic load_ok_o
);
  localparam int CNT_W = $clog2(STORE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STORE_CYC - 1);
  localparam logic [CNT_W-1:0] LLIM = CNT_W'(LOAD_CYC);

  logic             open_q;
  logic [CNT_W-1:0] cnt_q;

  // arming write outranks any strobe in the same cycle
  assign store_ok_o = open_q & store_i & ~arm_i & ~close_i;
  assign load_ok_o  = open_q & load_i & ~store_i & ~arm_i & ~close_i & (cnt_q < LLIM);
  assign open_o     = open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (arm_i) begin
      open_q <= 1'b1;
      cnt_q  <= '0;
    end else if (close_i) begin
      open_q <= 1'b0;
    end else if (open_q) begin
      if (store_ok_o || load_ok_o || cnt_q == LAST) open_q <= 1'b0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/nvw_nvstore.sv
module nvw_nvstore
  import nvw_pkg::*;
#(
  parameter int         PTR_W     = 16,
  parameter logic [5:0] LOCK_INIT = 6'h3F,
  parameter logic [7:0] FUSE_LO   = 8'h62,
  parameter logic [7:0] FUSE_HI   = 8'h99
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prog_i,
  input  logic [7:0]       data_i,
  input  logic [PTR_W-1:0] ptr_i,
  output logic [7:0]       rd_byte_o
);
  logic [7:0] lock_q;  // bits 7:6 held at 1

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lock_q <= {2'b11, LOCK_INIT};
    else if (prog_i) lock_q <= lock_q & (data_i | PROG_KEEP);
  end

  always_comb begin
    if      (ptr_i == PTR_W'(0)) rd_byte_o = FUSE_LO;
    else if (ptr_i == PTR_W'(1)) rd_byte_o = lock_q;
    else if (ptr_i == PTR_W'(3)) rd_byte_o = FUSE_HI;
    else                         rd_byte_o = RD_DEFAULT;
  end

  AST_LOCK_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q & ~$past(lock_q)) == 8'h00);  // R6
  AST_LOCK_FIXED_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i |=> lock_q[1:0] == $past(lock_q[1:0]));  // R6
endmodule

// File: rtl/nvm_cmd_window.sv
module nvm_cmd_window
  import nvw_pkg::*;
#(
  parameter int         PTR_W     = 16,
  parameter int         STORE_CYC = 4,
  parameter int         LOAD_CYC  = 3,
  parameter logic [5:0] LOCK_INIT = 6'h3F,
  parameter logic [7:0] FUSE_LO   = 8'h62,
  parameter logic [7:0] FUSE_HI   = 8'h99
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic [7:0]       ctrl_wdata_i,
  input  logic             store_i,
  input  logic             load_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [7:0]       data_i,
  input  logic             ee_busy_i,
  output logic [7:0]       ctrl_o,
  output logic             lock_we_o,
  output logic             rd_valid_o,
  output logic [7:0]       rd_data_o
);
  logic wr_ok, arm, close, open, store_ok, load_ok;
  logic [7:0] rd_byte;

  assign wr_ok = ctrl_we_i & ~ee_busy_i;
  assign arm   = wr_ok & is_arm(ctrl_wdata_i);
  assign close = wr_ok & ~is_arm(ctrl_wdata_i);

  nvw_window #(.STORE_CYC(STORE_CYC), .LOAD_CYC(LOAD_CYC)) u_win (
    .clk_i, .rst_ni,
    .arm_i     (arm),
    .close_i   (close),
    .store_i   (store_i & ~ee_busy_i),
    .load_i    (load_i & ~ee_busy_i),
    .open_o    (open),
    .store_ok_o(store_ok),
    .load_ok_o (load_ok)
  );

  nvw_nvstore #(.PTR_W(PTR_W), .LOCK_INIT(LOCK_INIT), .FUSE_LO(FUSE_LO), .FUSE_HI(FUSE_HI)) u_nv (
    .clk_i, .rst_ni,
    .prog_i   (store_ok),
    .data_i,
    .ptr_i,
    .rd_byte_o(rd_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_we_o  <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      lock_we_o  <= store_ok;
      rd_valid_o <= load_ok;
      if (load_ok) rd_data_o <= rd_byte;
    end
  end

  assign ctrl_o = open ? CTRL_ARMED : 8'h00;

  AST_CTRL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o == 8'h00 || ctrl_o == CTRL_ARMED);  // R1
  AST_WE_NEEDS_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_we_o |-> $past(ctrl_o[0] && store_i));  // R2
  AST_RD_NEEDS_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(ctrl_o[0] && load_i));  // R3
  AST_ACCEPT_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_we_o || rd_valid_o) |-> ctrl_o == 8'h00);  // R5
  AST_BUSY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ee_busy_i) |-> !lock_we_o && !rd_valid_o);  // R8
  AST_ARM_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[0]) |-> $past(ctrl_we_i && !ee_busy_i));  // R8
  AST_ONE_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lock_we_o && rd_valid_o));  // R11
endmodule

// File: tb/sim_nvm_cmd_window.sv
`timescale 1ns/1ps
module sim_nvm_cmd_window;
  localparam logic [7:0] FLO = 8'hE2;
  localparam logic [7:0] FHI = 8'hD9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, st = 1'b0, ld = 1'b0, busy = 1'b0;
  logic [7:0]  wd = '0, dat = '0;
  logic [15:0] ptr = '0;
  logic [7:0]  ctrl, rdata;
  logic        lwe, rv;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model
  int         m_age;   // -1 closed, else cycles since arming
  logic [5:0] m_lock;
  logic       m_we, m_rv;
  logic [7:0] m_rd;

  always #10 clk = ~clk;

  nvm_cmd_window #(.FUSE_LO(FLO), .FUSE_HI(FHI)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(we), .ctrl_wdata_i(wd),
    .store_i(st), .load_i(ld), .ptr_i(ptr), .data_i(dat), .ee_busy_i(busy),
    .ctrl_o(ctrl), .lock_we_o(lwe), .rd_valid_o(rv), .rd_data_o(rdata));

  function automatic logic [7:0] m_read(input logic [15:0] p);
    case (p)
      16'd0:   return FLO;
      16'd1:   return {2'b11, m_lock};
      16'd3:   return FHI;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    m_we = 0; m_rv = 0;
    if (we && !busy && wd[6:0] == 7'b0001001) m_age = 0;
    else if (we && !busy) m_age = -1;
    else if (m_age >= 0) begin
      if (st && !busy) begin
        m_lock[5:2] = m_lock[5:2] & dat[5:2];
        m_we = 1; m_age = -1;
      end else if (ld && !busy && m_age < 3) begin
        m_rd = m_read(ptr); m_rv = 1; m_age = -1;
      end else if (m_age == 3) m_age = -1;
      else m_age++;
    end
  endtask

  task automatic compare();
    chk(ctrl, (m_age >= 0) ? 8'h09 : 8'h00, "R1 R4 R5 R9 ctrl_o");
    chk({7'd0, lwe}, {7'd0, m_we}, "R2 R8 R11 lock_we_o");
    chk({7'd0, rv}, {7'd0, m_rv}, "R3 R8 R10 rd_valid_o");
    if (m_rv) chk(rdata, m_rd, "R6 R7 rd_data_o");
  endtask

  task automatic cyc();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    if (rst_n) compare();
  endtask

  task automatic idle_in();
    we = 0; st = 0; ld = 0; busy = 0;
  endtask

  task automatic do_reset();
    idle_in();
    rst_n = 0;
    m_age = -1; m_lock = 6'h3F; m_we = 0; m_rv = 0; m_rd = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic arm(input logic b7);
    idle_in(); we = 1; wd = {b7, 7'b0001001}; cyc(); idle_in();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk(ctrl, 8'h00, "R1 reset ctrl_o");
    chk({6'd0, lwe, rv}, 8'h00, "R2 R3 reset strobes");

    // R1 bit 7 don't care, R3 load in first cycle, R7 low fuse
    arm(1'b1);
    chk(ctrl, 8'h09, "R1 armed");
    ld = 1; ptr = 16'd0; cyc(); idle_in();
    chk({7'd0, rv}, 8'd1, "R3 load first cycle");
    chk(rdata, FLO, "R7 fuse low");
    chk(ctrl, 8'h00, "R5 closed after read");

    // R3 load in third cycle, high fuse
    arm(1'b0); cyc(); cyc();
    ld = 1; ptr = 16'd3; cyc(); idle_in();
    chk({7'd0, rv}, 8'd1, "R3 load third cycle");
    chk(rdata, FHI, "R7 fuse high");

    // R4 load in fourth cycle refused, then expiry
    arm(1'b0); cyc(); cyc(); cyc();
    ld = 1; ptr = 16'd1; cyc(); idle_in();
    chk({7'd0, rv}, 8'd0, "R4 late load refused");
    chk(ctrl, 8'h00, "R4 expired");
    // R10 load with window closed
    ld = 1; cyc(); idle_in();
    chk({7'd0, rv}, 8'd0, "R10 load closed");

    // R2 store in fourth cycle, R6 program bit 3 only, pointer ignored
    arm(1'b0); cyc(); cyc(); cyc();
    st = 1; dat = 8'b0011_0100 ^ 8'h3C ^ 8'h3C; dat = 8'h37; ptr = 16'hBEEF; cyc(); idle_in();
    chk({7'd0, lwe}, 8'd1, "R2 store fourth cycle");
    chk(ctrl, 8'h00, "R5 closed after store");
    cyc();
    chk({7'd0, lwe}, 8'd0, "R2 single pulse");
    arm(1'b0); ld = 1; ptr = 16'd1; cyc(); idle_in();
    chk(rdata, 8'hF7, "R6 bit3 cleared");

    // R6 zeros outside 5..2 ignored, bits never rise
    arm(1'b0); st = 1; dat = 8'h3C; cyc(); idle_in();
    arm(1'b0); st = 1; dat = 8'hFF; cyc(); idle_in();
    arm(1'b0); ld = 1; ptr = 16'd1; cyc(); idle_in();
    chk(rdata, 8'hF7, "R6 no change and no rise");

    // R7 unlisted pointer
    arm(1'b0); ld = 1; ptr = 16'd2; cyc(); idle_in();
    chk(rdata, 8'hFF, "R7 unlisted pointer");

    // R1 other value closes
    arm(1'b0); we = 1; wd = 8'h01; cyc(); idle_in();
    chk(ctrl, 8'h00, "R1 other write closes");

    // R8 busy blocks arming and strobes, window keeps aging
    busy = 1; we = 1; wd = 8'h09; cyc(); idle_in();
    chk(ctrl, 8'h00, "R8 arm blocked");
    arm(1'b0); busy = 1; st = 1; dat = 8'h00; cyc(); idle_in();
    chk({7'd0, lwe}, 8'd0, "R8 store blocked");
    chk(ctrl, 8'h09, "R8 window still open");
    cyc(); cyc(); cyc();
    chk(ctrl, 8'h00, "R8 window aged out");

    // R9 rearm restarts count
    arm(1'b0); cyc(); cyc(); arm(1'b0); cyc(); cyc(); cyc();
    chk(ctrl, 8'h09, "R9 still open after rearm");
    st = 1; dat = 8'hDF; cyc(); idle_in();
    chk({7'd0, lwe}, 8'd1, "R9 store after rearm");

    // R11 store wins over load
    arm(1'b0); st = 1; ld = 1; dat = 8'hFF; ptr = 16'd0; cyc(); idle_in();
    chk({7'd0, lwe}, 8'd1, "R11 store taken");
    chk({7'd0, rv}, 8'd0, "R11 load dropped");

    // random phase
    for (int blk = 0; blk < 8; blk++) begin
      do_reset();
      for (int i = 0; i < 1500; i++) begin
        we   = ($urandom_range(0, 9) < 2);
        wd   = ($urandom_range(0, 9) < 7) ? {1'($urandom), 7'b0001001} : 8'($urandom);
        st   = ($urandom_range(0, 19) < 2);
        ld   = ($urandom_range(0, 19) < 3);
        busy = ($urandom_range(0, 9) < 1);
        ptr  = ($urandom_range(0, 4) == 4) ? 16'($urandom) : 16'($urandom_range(0, 3));
        dat  = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'hFF;
        cyc();
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule